// File: doc/BRIEF.md
# Indirect Volume Register Port for an Analog Mixer

This block lets a host program the gain settings of an analog mixer through a 6-bit asynchronous parallel port. The host drives four control lines: chip select, write strobe, read strobe and register select. With register select low, an access reaches a pointer register. With it high, the access reaches the volume register that the pointer names. To program a volume, the host first writes the pointer and then writes the data.

The block holds nineteen 6-bit volume registers. Registers 0 to 8 set the volume of each source into the converter mix: IN1L, IN1R, IN2L, IN2R, IN3L, IN3R, IN4L, IN4R, and the single mono source. Registers 9 to 18 set the volume of each source into the output mix, from IN1L into the left output through the right DAC into the right output. For every register, the block drives a decoded attenuation step and a mute flag to the mixer.

The block also drives the enable and direction lines of an external bus transceiver. The strobes and bus lines are synchronized to the internal clock before use.

Top module: `mixvol_host_port`

## Requirements
- R1: A write with `sel`=0 loads `bus_in` into the 6-bit pointer register. The pointer resets to 0. It changes only on a pointer write and never increments on its own. A read with `sel`=0 returns the pointer on `bus_out`.
- R2: A write with `sel`=1 stores `bus_in` into the volume register at the pointer's address. The store is committed when the synchronized write strobe returns high. The value held on the bus while the strobe was low is the value stored.
- R3: While `cs_n` is high, `bus_oe` is 0 and `xcvr_en_n` is 1. Write and read strobes given while `cs_n` is high change no register.
- R4: A read with `cs_n`=0, `rd_n`=0 and `sel`=1 drives the addressed volume register on `bus_out` with `bus_oe`=1. The value appears three clock cycles after the strobe falls.
- R5: `xcvr_dir` is 1 while the data pins are inputs and 0 while the block drives them, so `xcvr_dir` equals the inverse of `bus_oe`. `xcvr_en_n` is 0 while the chip is selected.
- R6: After reset, every volume register reads 6'b100000. All 19 `mute` bits are 1 and all `gain_step` fields are 0.
- R7: For register i, `mute[i]` is bit 5 of the register. When bit 5 is 0, `gain_step[5i+4:5i]` equals bits 4..0 (attenuation = code × 1.5 dB, 0 to −46.5 dB). When bit 5 is 1, the step is 0, whatever bits 4..0 hold.
- R8: A data write when the pointer is between 19 and 63 changes nothing. A data read at such a pointer returns 0.
- R9: If the write and read strobes are low together, the access is a read: the bus is driven, and no register is written when the strobes rise.
- R10: The output vectors are indexed by register address. Address 8 is the mono input volume, and address 17 is the left DAC into the left output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| sel | input | 1 | 0 = pointer register, 1 = volume data register |
| bus_in | input | 6 | Data from the host |
| bus_out | output | 6 | Data to the host |
| bus_oe | output | 1 | High while the block drives the data pins |
| xcvr_en_n | output | 1 | Transceiver enable, low while selected |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward the block |
| mute | output | 19 | Mute flag per volume register |
| gain_step | output | 95 | 5-bit attenuation step per register, register i at bits 5i+4..5i |

## Verification
On every cycle, the assertions check these relations:
- the transceiver enable is active whenever the bus is driven;
- no register shows both mute and a nonzero step;
- all channels are muted right after reset;
- the pointer holds between pointer writes;
- the mixer outputs stay still unless a data write has just been committed.

Some behaviour can only be shown by the bench's scenarios, which read back and watch the mixer vectors:
- the address mapping;
- the value that is stored and the pointer-versus-data selection;
- ignoring out-of-range addresses and deselected strobes;
- read priority when both strobes are low.

// File: rtl/mixvol_pkg.sv
package mixvol_pkg;
  localparam int VOL_W    = 6;
  localparam int VOL_REGS = 19;
  localparam logic [VOL_W-1:0] VOL_RESET = {1'b1, {(VOL_W-1){1'b0}}};
endpackage

// File: rtl/mixvol_sync.sv
module mixvol_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= INIT;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mixvol_regfile.sv
module mixvol_regfile #(
  parameter int DW = 6,
  parameter int NREG = 19,
  parameter int AW = 6,
  parameter logic [DW-1:0] RST_VAL = {1'b1, {(DW-1){1'b0}}}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [NREG*DW-1:0] vol_flat
);
  logic [DW-1:0] vol [NREG];

  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) vol[i] <= RST_VAL;
        else if (we && (addr == AW'(i))) vol[i] <= wdata;
      end
      assign vol_flat[i*DW +: DW] = vol[i];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NREG; k++)
      if (addr == AW'(k)) rdata = vol[k];
  end
endmodule

// File: rtl/mixvol_decode.sv
module mixvol_decode #(
  parameter int DW = 6,
  parameter int NREG = 19,
  localparam int SW = DW - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NREG*DW-1:0] vol_flat,
  output logic [NREG-1:0]    mute,
  output logic [NREG*SW-1:0] gain_step
);
  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_ch
      logic [DW-1:0] v;
      assign v = vol_flat[i*DW +: DW];
      always_ff @(posedge clk) begin
        if (rst) begin
          mute[i] <= 1'b1;
          gain_step[i*SW +: SW] <= '0;
        end else begin
          mute[i] <= v[DW-1];
          gain_step[i*SW +: SW] <= v[DW-1] ? '0 : v[SW-1:0];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mixvol_host_port.sv
module mixvol_host_port #(
  parameter int DW = mixvol_pkg::VOL_W,
  parameter int NREG = mixvol_pkg::VOL_REGS,
  parameter int SYNC_STAGES = 2,
  localparam int SW = DW - 1,
  localparam int CW = DW + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               wr_n,
  input  logic               rd_n,
  input  logic               sel,
  input  logic [DW-1:0]      bus_in,
  output logic [DW-1:0]      bus_out,
  output logic               bus_oe,
  output logic               xcvr_en_n,
  output logic               xcvr_dir,
  output logic [NREG-1:0]    mute,
  output logic [NREG*SW-1:0] gain_step
);
  // Synchronized host lines: {cs_n, wr_n, rd_n, sel, data}
  logic [CW-1:0] s_all;
  logic s_cs, s_wr, s_rd, s_sel;
  logic [DW-1:0] s_dat;

  mixvol_sync #(.W(CW), .STAGES(SYNC_STAGES),
                .INIT({4'b1110, {DW{1'b0}}})) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, wr_n, rd_n, sel, bus_in}),
    .q(s_all)
  );
  assign {s_cs, s_wr, s_rd, s_sel, s_dat} = s_all;

  // One-cycle delayed copies for edge detection
  logic q_cs, q_wr, q_rd, q_sel;
  logic [DW-1:0] q_dat;
  always_ff @(posedge clk) begin
    if (rst) begin
      q_cs <= 1'b1; q_wr <= 1'b1; q_rd <= 1'b1; q_sel <= 1'b0;
      q_dat <= '0;
    end else begin
      q_cs <= s_cs; q_wr <= s_wr; q_rd <= s_rd; q_sel <= s_sel;
      q_dat <= s_dat;
    end
  end

  // Commit on the strobe's rising edge; a pending read wins
  logic commit, addr_we, data_we;
  assign commit  = s_wr & ~q_wr & ~q_cs & q_rd;
  assign addr_we = commit & ~q_sel;
  assign data_we = commit &  q_sel;

  logic [DW-1:0] addr_q;
  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (addr_we) addr_q <= q_dat;
  end

  logic [DW-1:0] rdata;
  logic [NREG*DW-1:0] vol_flat;

  mixvol_regfile #(.DW(DW), .NREG(NREG), .AW(DW),
                   .RST_VAL(mixvol_pkg::VOL_RESET)) u_regs (
    .clk(clk), .rst(rst), .we(data_we), .addr(addr_q),
    .wdata(q_dat), .rdata(rdata), .vol_flat(vol_flat)
  );

  mixvol_decode #(.DW(DW), .NREG(NREG)) u_dec (
    .clk(clk), .rst(rst), .vol_flat(vol_flat),
    .mute(mute), .gain_step(gain_step)
  );

  // Registered bus side and transceiver controls
  logic rd_active;
  assign rd_active = ~s_cs & ~s_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe    <= 1'b0;
      bus_out   <= '0;
      xcvr_dir  <= 1'b1;
      xcvr_en_n <= 1'b1;
    end else begin
      bus_oe    <= rd_active;
      bus_out   <= rd_active ? (s_sel ? rdata : addr_q) : '0;
      xcvr_dir  <= ~rd_active;
      xcvr_en_n <= s_cs;
    end
  end
endmodule

// File: rtl/mixvol_checker.sv
module mixvol_checker #(
  parameter int NREG = 19,
  parameter int SW = 5,
  parameter int DW = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_oe,
  input logic               xcvr_en_n,
  input logic [NREG-1:0]    mute,
  input logic [NREG*SW-1:0] gain_step,
  input logic [DW-1:0]      addr_q,
  input logic               addr_we,
  input logic               data_we
);
  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int k = 0; k < NREG; k++)
      if (mute[k] && (gain_step[k*SW +: SW] != '0)) clash = 1'b1;
  end

  AST_OE_WHILE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !xcvr_en_n); // R5

  AST_MUTE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    !clash); // R7

  AST_RESET_ALL_MUTED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mute)); // R6

  AST_POINTER_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !addr_we |=> $stable(addr_q)); // R1

  AST_MIX_STILL_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!data_we && !$past(data_we)) |=> ($stable(mute) && $stable(gain_step))); // R2
endmodule

bind mixvol_host_port mixvol_checker #(.NREG(NREG), .SW(SW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_oe(bus_oe), .xcvr_en_n(xcvr_en_n),
  .mute(mute), .gain_step(gain_step), .addr_q(addr_q),
  .addr_we(addr_we), .data_we(data_we)
);

// File: tb/mixvol_host_port_test.sv
module mixvol_host_port_test;
  localparam int DW = 6, NREG = 19, SW = 5;

  logic clk = 0, rst = 1;
  logic cs_n = 1, wr_n = 1, rd_n = 1, sel = 0;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out;
  logic bus_oe, xcvr_en_n, xcvr_dir;
  logic [NREG-1:0] mute;
  logic [NREG*SW-1:0] gain_step;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [NREG];

  always #4 clk = ~clk;

  mixvol_host_port uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .sel(sel),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir),
    .mute(mute), .gain_step(gain_step)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(logic s, logic [DW-1:0] v, logic selected = 1'b1);
    cs_n = ~selected; sel = s; bus_in = v; wait_cyc(3);
    wr_n = 0; wait_cyc(4);
    wr_n = 1; wait_cyc(3);
    cs_n = 1; wait_cyc(4);
    if (s && selected && model_idx_ok()) model[cur_ptr] = v;
  endtask

  logic [DW-1:0] cur_ptr = '0;
  function automatic bit model_idx_ok();
    return int'(cur_ptr) < NREG;
  endfunction

  task automatic set_ptr(logic [DW-1:0] a);
    host_write(1'b0, a);
    cur_ptr = a;
  endtask

  task automatic host_read(logic s, output logic [DW-1:0] v, output logic oe, output logic dir);
    cs_n = 0; sel = s; wait_cyc(2);
    rd_n = 0; wait_cyc(5);
    v = bus_out; oe = bus_oe; dir = xcvr_dir;
    rd_n = 1; wait_cyc(4);
    cs_n = 1; wait_cyc(4);
  endtask

  task automatic check_mix(string req);
    logic [NREG-1:0] em;
    logic [NREG*SW-1:0] eg;
    for (int i = 0; i < NREG; i++) begin
      em[i] = model[i][5];
      eg[i*SW +: SW] = model[i][5] ? 5'd0 : model[i][4:0];
    end
    chk({req, " mute"}, 128'(mute), 128'(em));
    chk({req, " step"}, 128'(gain_step), 128'(eg));
  endtask

  task automatic t_reset;
    logic [DW-1:0] v; logic oe, dir;
    chk("R6 mute after reset", 128'(mute), 128'({NREG{1'b1}}));
    chk("R6 step after reset", 128'(gain_step), 128'(0));
    chk("R3 idle oe", 128'(bus_oe), 128'(0));
    chk("R5 idle en_n", 128'(xcvr_en_n), 128'(1));
    chk("R5 idle dir", 128'(xcvr_dir), 128'(1));
    host_read(1'b0, v, oe, dir);
    chk("R1 pointer reset 0", 128'(v), 128'(0));
    host_read(1'b1, v, oe, dir);
    chk("R6 reg0 reads 100000", 128'(v), 128'(6'b100000));
    chk("R4 oe during read", 128'(oe), 128'(1));
    chk("R5 dir during read", 128'(dir), 128'(0));
  endtask

  task automatic t_write_map;
    logic [DW-1:0] v; logic oe, dir;
    set_ptr(6'd8); host_write(1'b1, 6'd7);
    set_ptr(6'd17); host_write(1'b1, 6'd31);
    set_ptr(6'd0); host_write(1'b1, 6'd0);
    set_ptr(6'd18); host_write(1'b1, 6'b111111);
    check_mix("R10 R2 map");
    chk("R10 mono unmuted", 128'(mute[8]), 128'(0));
    chk("R10 dac left step", 128'(gain_step[17*SW +: SW]), 128'(31));
    chk("R7 mute ignores low bits", 128'(gain_step[18*SW +: SW]), 128'(0));
    host_read(1'b0, v, oe, dir);
    chk("R1 pointer holds, no increment", 128'(v), 128'(18));
    set_ptr(6'd17); host_read(1'b1, v, oe, dir);
    chk("R4 readback reg17", 128'(v), 128'(31));
  endtask

  task automatic t_deselected;
    logic [DW-1:0] v; logic oe, dir;
    set_ptr(6'd3);
    host_write(1'b1, 6'd5, 1'b0);
    cs_n = 1; sel = 1; rd_n = 0; wait_cyc(5);
    chk("R3 no drive when deselected", 128'(bus_oe), 128'(0));
    chk("R3 en_n high when deselected", 128'(xcvr_en_n), 128'(1));
    rd_n = 1; wait_cyc(4);
    check_mix("R3 deselected write ignored");
    host_read(1'b1, v, oe, dir);
    chk("R3 reg3 unchanged", 128'(v), 128'(6'b100000));
  endtask

  task automatic t_out_of_range;
    logic [DW-1:0] v; logic oe, dir;
    set_ptr(6'd19); host_write(1'b1, 6'd9);
    set_ptr(6'd63); host_write(1'b1, 6'd1);
    check_mix("R8 oor write ignored");
    host_read(1'b1, v, oe, dir);
    chk("R8 oor read zero", 128'(v), 128'(0));
  endtask

  task automatic t_both_strobes;
    logic [DW-1:0] v; logic oe, dir;
    set_ptr(6'd4);
    cs_n = 0; sel = 1; bus_in = 6'd12; wait_cyc(3);
    wr_n = 0; rd_n = 0; wait_cyc(5);
    chk("R9 treated as read oe", 128'(bus_oe), 128'(1));
    chk("R9 read data", 128'(bus_out), 128'(6'b100000));
    wr_n = 1; rd_n = 1; wait_cyc(4);
    cs_n = 1; wait_cyc(4);
    check_mix("R9 no write");
    host_read(1'b1, v, oe, dir);
    chk("R9 reg4 unchanged", 128'(v), 128'(6'b100000));
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 6'b100000;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    wait_cyc(2);
    t_reset();
    t_write_map();
    t_deselected();
    t_out_of_range();
    t_both_strobes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule